// File: doc/BRIEF.md
# Timing Bus Master Role Controller

This block holds the host-visible configuration for a device that can act as clock master on a shared telephony timing bus. The bus carries a bit clock and a frame pulse on two redundant signal sets, A and B. The host chooses whether the device drives the bus, which set it drives, whether it acts as primary or secondary master, whether output timing is advanced by one fast-clock period, and whether a secondary may take over on its own. A read-only bit reports the role actually in effect.

As secondary, the device drives one set and watches the other as its reference. A monitor flags a reference error when the frame pulse goes missing or the reference clock stops toggling for a programmable window of fast-clock cycles. In automatic mode such an error makes the secondary take the primary role at the next local frame boundary. It then stays primary until the host clears automatic mode. The PLL and the pad drivers sit outside this block. The block supplies per-set drive enables, the reference-set select, an advance indication and the local frame strobe.

Top module: `tbus_master_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x08, both drive enables are low, ref_sel_b_o is high, adv_active_o and role_sec_o are low, and no frame strobe is produced.
- R2: Address 0 holds the configuration: bit 0 enable, bit 1 set B select, bit 2 timing advance, bit 3 automatic mode, bit 4 secondary request, bit 5 role status (read-only, 1 = secondary). Bits 6 and 7 read 0 and ignore writes. Address 1 is the 8-bit error window. Addresses 2 and 3 read 0 and ignore writes.
- R3: drive_a_o is high only when enable is 1 and set select is 0. drive_b_o is high only when enable is 1 and set select is 1.
- R4: ref_sel_b_o is the inverse of the set select: the reference is always the set that is not driven.
- R5: adv_active_o is high exactly when the advance bit is 1 and the role in effect is secondary. While it is high, the frame strobe comes one cycle earlier, so the frame in which advance turns on lasts FRAME_LEN-1 cycles.
- R6: A reference error is raised when no frame rising edge arrives on the reference set for FRAME_LEN plus window cycles, or when the reference clock level does not change for window cycles. While the reference is healthy, the role does not change.
- R7: In automatic mode, a secondary that sees a reference error becomes primary. role_sec_o and status bit 5 then read 0 even though bit 4 still reads 1.
- R8: An automatic promotion takes effect in the cycle right after a local frame boundary, and the frame strobe period stays FRAME_LEN across it.
- R9: After an automatic promotion, writes that keep automatic mode on leave the role primary. The write that clears automatic mode returns the block to ordinary primary. A later write with bit 4 set makes it secondary.
- R10: A reference error does not change the role in manual mode or while the role is primary. In the primary role the advance bit has no effect on adv_active_o.
- R11: With enable 1 the frame strobe is a one-cycle pulse every FRAME_LEN cycles. With enable 0 there is none.
- R12: When a configuration write lands in the same cycle as the frame boundary that would finish a pending promotion, a write that clears automatic mode cancels the promotion. A write that keeps automatic mode on does not delay it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Register write strobe |
| host_addr_i | input | ADDR_W | Register address for read and write |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data of the addressed register |
| refa_clk_i | input | 1 | Bit clock observed on set A |
| refa_frame_i | input | 1 | Frame pulse observed on set A |
| refb_clk_i | input | 1 | Bit clock observed on set B |
| refb_frame_i | input | 1 | Frame pulse observed on set B |
| drive_a_o | output | 1 | Enable for driving set A |
| drive_b_o | output | 1 | Enable for driving set B |
| ref_sel_b_o | output | 1 | 1 when set B is the reference |
| adv_active_o | output | 1 | Timing advance in effect |
| frame_strobe_o | output | 1 | Local frame strobe |
| role_sec_o | output | 1 | Role in effect, 1 = secondary |

## Verification
The two functions that can fall in one cycle are the frame boundary that completes a pending automatic promotion and a host write to the configuration register. The bench stalls the reference clock one cycle after a strobe, so the error arises well inside the frame. It then times a write to be sampled exactly on the following boundary cycle. One pass writes a value that keeps automatic mode on and expects role_sec_o low in the next cycle. The other pass clears automatic mode and expects the secondary role to hold, both then and a hundred cycles later.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

  localparam int DATA_W = 8;
  localparam int CFG_W  = 5;

  // configuration fields, LSB first: enable, set B, advance, auto, secondary
  typedef struct packed {
    logic sec_req;
    logic auto_en;
    logic advance;
    logic set_b;
    logic enable;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_PRI  = 2'd0,   // primary chosen by host
    ST_SEC  = 2'd1,   // secondary, tracking reference
    ST_PEND = 2'd2,   // secondary, promotion waiting for frame boundary
    ST_APRI = 2'd3    // primary after automatic promotion, latched
  } role_st_t;

endpackage

// File: rtl/tbus_regs.sv
module tbus_regs
  import tbus_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int WIN_W   = 8,
  parameter int WIN_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              role_sec_i,
  output cfg_t              cfg_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              cfg_wr_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = '0;
  localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(1);
  localparam int                PAD_W    = DATA_W - CFG_W - 1;

  cfg_t             cfg_q, cfg_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             cfg_hit, win_hit;
  logic             unused_hi;

  assign cfg_hit   = wr_i && (addr_i == CFG_ADDR);
  assign win_hit   = wr_i && (addr_i == WIN_ADDR);
  assign unused_hi = ^wdata_i[DATA_W-1:CFG_W];

  always_comb begin
    cfg_d = cfg_q;
    win_d = win_q;
    if (cfg_hit) cfg_d = cfg_t'(wdata_i[CFG_W-1:0]);
    if (win_hit) win_d = wdata_i[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      win_q <= WIN_W'(WIN_RST);
    end else begin
      cfg_q <= cfg_d;
      win_q <= win_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      CFG_ADDR: rdata_o = {{PAD_W{1'b0}}, role_sec_i, cfg_q};
      WIN_ADDR: rdata_o = DATA_W'(win_q);
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign win_o    = win_q;
  assign cfg_wr_o = cfg_hit;

endmodule

// File: rtl/tbus_ref_mon.sv
module tbus_ref_mon #(
  parameter int FRAME_LEN   = 32,
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_clk_i,
  input  logic             a_frame_i,
  input  logic             b_clk_i,
  input  logic             b_frame_i,
  input  logic             sel_b_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             err_o
);

  localparam int              SW = 4 * SYNC_STAGES;
  localparam logic [CNT_W-1:0] FL = CNT_W'(FRAME_LEN);

  logic [3:0]       raw;
  logic [SW-1:0]    sh_q, sh_d;
  logic [3:0]       now_s, prev_q;
  logic             clk_now, clk_prev, frm_now, frm_prev;
  logic             toggle, frm_rise;
  logic [CNT_W-1:0] frm_cnt_q, frm_cnt_d, stall_q, stall_d;
  logic [CNT_W-1:0] frm_lim, stall_lim;
  logic             err_d, err_q;

  assign raw = {b_frame_i, b_clk_i, a_frame_i, a_clk_i};

  // synchronizer depth picked by parameter
  if (SYNC_STAGES > 1) begin : g_deep
    assign sh_d = {sh_q[SW-5:0], raw};
  end else begin : g_single
    assign sh_d = raw;
  end

  assign now_s = sh_q[SW-1 -: 4];

  assign clk_now  = sel_b_i ? now_s[2]  : now_s[0];
  assign clk_prev = sel_b_i ? prev_q[2] : prev_q[0];
  assign frm_now  = sel_b_i ? now_s[3]  : now_s[1];
  assign frm_prev = sel_b_i ? prev_q[3] : prev_q[1];

  assign toggle   = clk_now ^ clk_prev;
  assign frm_rise = frm_now & ~frm_prev;

  assign frm_lim   = FL + CNT_W'(win_i);
  assign stall_lim = CNT_W'(win_i);

  always_comb begin
    frm_cnt_d = frm_cnt_q;
    stall_d   = stall_q;
    if (frm_rise)         frm_cnt_d = '0;
    else if (~&frm_cnt_q) frm_cnt_d = frm_cnt_q + CNT_W'(1);
    if (toggle)           stall_d = '0;
    else if (~&stall_q)   stall_d = stall_q + CNT_W'(1);
    err_d = (frm_cnt_q >= frm_lim) || (stall_q >= stall_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      prev_q    <= '0;
      frm_cnt_q <= '0;
      stall_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      prev_q    <= now_s;
      frm_cnt_q <= frm_cnt_d;
      stall_q   <= stall_d;
      err_q     <= err_d;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/tbus_frame_gen.sv
module tbus_frame_gen #(
  parameter int FRAME_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic adv_i,
  output logic bnd_o,
  output logic strobe_o
);

  localparam int              LEN_W = $clog2(FRAME_LEN);
  localparam logic [LEN_W-1:0] LAST  = LEN_W'(FRAME_LEN - 1);
  localparam logic [LEN_W-1:0] EARLY = LEN_W'(FRAME_LEN - 2);

  logic [LEN_W-1:0] cnt_q, cnt_d;

  assign bnd_o = (cnt_q == LAST);
  assign cnt_d = bnd_o ? '0 : cnt_q + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe_o = en_i && (adv_i ? (cnt_q == EARLY) : bnd_o);

endmodule

// File: rtl/tbus_role_fsm.sv
module tbus_role_fsm
  import tbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr_i,
  input  logic wr_sec_i,
  input  logic wr_auto_i,
  input  logic auto_q_i,
  input  logic err_i,
  input  logic bnd_i,
  output logic role_sec_o
);

  role_st_t st_q, st_d;
  logic     auto_eff, sec_eff;

  // a write in this cycle overrides the stored mode bits
  assign auto_eff = cfg_wr_i ? wr_auto_i : auto_q_i;
  assign sec_eff  = cfg_wr_i ? wr_sec_i  : 1'b1;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PRI:  if (cfg_wr_i && wr_sec_i) st_d = ST_SEC;
      ST_SEC: begin
        if (!sec_eff)               st_d = ST_PRI;
        else if (auto_eff && err_i) st_d = ST_PEND;
      end
      ST_PEND: begin
        if (!sec_eff)       st_d = ST_PRI;
        else if (!auto_eff) st_d = ST_SEC;
        else if (bnd_i)     st_d = ST_APRI;
      end
      ST_APRI: if (cfg_wr_i && !wr_auto_i) st_d = ST_PRI;
      default: st_d = ST_PRI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PRI;
    else        st_q <= st_d;
  end

  assign role_sec_o = (st_q == ST_SEC) || (st_q == ST_PEND);

endmodule

// File: rtl/tbus_master_ctrl.sv
module tbus_master_ctrl
  import tbus_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int FRAME_LEN   = 32,
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 8,
  parameter int WIN_RST     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic              refa_clk_i,
  input  logic              refa_frame_i,
  input  logic              refb_clk_i,
  input  logic              refb_frame_i,
  output logic              drive_a_o,
  output logic              drive_b_o,
  output logic              ref_sel_b_o,
  output logic              adv_active_o,
  output logic              frame_strobe_o,
  output logic              role_sec_o
);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  cfg_t             cfg;
  logic [WIN_W-1:0] win;
  logic             cfg_wr, ref_err, frame_bnd, role_sec, adv_on;
  logic             unused_sec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  tbus_regs #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_RST(WIN_RST)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_i(host_wr_i), .addr_i(host_addr_i),
    .wdata_i(host_wdata_i), .role_sec_i(role_sec), .cfg_o(cfg), .win_o(win),
    .cfg_wr_o(cfg_wr), .rdata_o(host_rdata_o)
  );

  tbus_ref_mon #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .WIN_W(WIN_W),
                 .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(core_rst_n), .a_clk_i(refa_clk_i), .a_frame_i(refa_frame_i),
    .b_clk_i(refb_clk_i), .b_frame_i(refb_frame_i), .sel_b_i(~cfg.set_b),
    .win_i(win), .err_o(ref_err)
  );

  tbus_role_fsm u_fsm (
    .clk(clk), .rst_n(core_rst_n), .cfg_wr_i(cfg_wr),
    .wr_sec_i(host_wdata_i[4]), .wr_auto_i(host_wdata_i[3]),
    .auto_q_i(cfg.auto_en), .err_i(ref_err), .bnd_i(frame_bnd),
    .role_sec_o(role_sec)
  );

  assign adv_on = cfg.advance && role_sec;

  tbus_frame_gen #(.FRAME_LEN(FRAME_LEN)) u_fgen (
    .clk(clk), .rst_n(core_rst_n), .en_i(cfg.enable), .adv_i(adv_on),
    .bnd_o(frame_bnd), .strobe_o(frame_strobe_o)
  );

  assign unused_sec   = cfg.sec_req;
  assign drive_a_o    = cfg.enable && !cfg.set_b;
  assign drive_b_o    = cfg.enable && cfg.set_b;
  assign ref_sel_b_o  = !cfg.set_b;
  assign adv_active_o = adv_on;
  assign role_sec_o   = role_sec;

endmodule

// File: rtl/tbus_master_ctrl_chk.sv
module tbus_master_ctrl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [7:0]        host_wdata_i,
  input logic              drive_a_o,
  input logic              drive_b_o,
  input logic              ref_sel_b_o,
  input logic              adv_active_o,
  input logic              frame_strobe_o,
  input logic              role_sec_o,
  input logic              bnd
);

  p_one_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_a_o && drive_b_o));

  p_ref_b_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_b_o |-> !ref_sel_b_o);

  p_ref_a_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_a_o |-> ref_sel_b_o);

  p_adv_secondary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_active_o |-> role_sec_o);

  p_promote_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(role_sec_o) && !$past(host_wr_i)) |-> $past(bnd));

  p_demote_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(role_sec_o) |-> $past(host_wr_i && (host_addr_i == '0) && host_wdata_i[4]));

  p_strobe_when_driving_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe_o |-> (drive_a_o || drive_b_o));

endmodule

bind tbus_master_ctrl tbus_master_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
  .host_wdata_i(host_wdata_i), .drive_a_o(drive_a_o), .drive_b_o(drive_b_o),
  .ref_sel_b_o(ref_sel_b_o), .adv_active_o(adv_active_o),
  .frame_strobe_o(frame_strobe_o), .role_sec_o(role_sec_o), .bnd(frame_bnd)
);

// File: tb/tb_tbus_master_ctrl.sv
`timescale 1ns/1ps
module tb_tbus_master_ctrl;

  localparam int FLEN = 32;
  localparam int NVEC = 11;

  // {addr, wdata, expected rdata, drive_a, drive_b, ref_sel_b}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 8'h01, 8'h01, 3'b101},   // R3 drive A
    {2'd0, 8'h03, 8'h03, 3'b010},   // R3 R4 drive B
    {2'd0, 8'h02, 8'h02, 3'b000},   // R3 disabled
    {2'd0, 8'hC1, 8'h01, 3'b101},   // R2 reserved bits
    {2'd0, 8'h20, 8'h00, 3'b001},   // R2 status read-only
    {2'd0, 8'h13, 8'h33, 3'b010},   // R2 secondary status
    {2'd0, 8'h01, 8'h01, 3'b101},
    {2'd1, 8'h0C, 8'h0C, 3'b101},   // R2 window
    {2'd2, 8'hFF, 8'h00, 3'b101},   // R2 unused address
    {2'd3, 8'h5A, 8'h00, 3'b101},
    {2'd1, 8'h08, 8'h08, 3'b101}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       ra_clk = 0, ra_frm = 0, rb_clk = 0, rb_frm = 0;
  logic       clk_a_on = 1, clk_b_on = 1, frm_a_on = 1, frm_b_on = 1;
  logic       drive_a, drive_b, ref_sel_b, adv_active, frame_strobe, role_sec;
  int         gen_cnt = 0;
  int         cyc = 0;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    gen_cnt <= (gen_cnt == FLEN - 1) ? 0 : gen_cnt + 1;
    if (clk_a_on) ra_clk <= ~ra_clk;
    if (clk_b_on) rb_clk <= ~rb_clk;
    ra_frm <= frm_a_on && (gen_cnt == 0);
    rb_frm <= frm_b_on && (gen_cnt == 0);
  end

  tbus_master_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .refa_clk_i(ra_clk), .refa_frame_i(ra_frm), .refb_clk_i(rb_clk), .refb_frame_i(rb_frm),
    .drive_a_o(drive_a), .drive_b_o(drive_b), .ref_sel_b_o(ref_sel_b),
    .adv_active_o(adv_active), .frame_strobe_o(frame_strobe), .role_sec_o(role_sec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #0.5 d = host_rdata;
  endtask

  task automatic wait_strobe(output int t);
    do @(negedge clk); while (!frame_strobe);
    t = cyc;
  endtask

  // stalls the B clock one cycle after a strobe, then writes d on the boundary
  task automatic boundary_write(input logic [7:0] d);
    int t;
    wait_strobe(t);
    @(negedge clk);
    clk_b_on = 0;
    repeat (FLEN - 2) @(negedge clk);
    chk(role_sec == 1'b1, "R8 still secondary before boundary", role_sec, 1);
    @(negedge clk);
    host_wr = 1; host_addr = 2'd0; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 2000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int t0, t1, t2, seen;
    bit prev_s, found;

    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk(d == 8'h00, "R1 cfg reset", d, 8'h00);
    rd(2'd1, d); chk(d == 8'h08, "R1 window reset", d, 8'h08);
    chk({drive_a, drive_b, ref_sel_b, adv_active, role_sec} == 5'b00100,
        "R1 outputs reset", {drive_a, drive_b, ref_sel_b, adv_active, role_sec}, 5'b00100);
    seen = 0;
    for (int i = 0; i < 2 * FLEN; i++) begin
      @(negedge clk);
      if (frame_strobe) seen++;
    end
    chk(seen == 0, "R11 no strobe when disabled", seen, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][20:19], VEC[i][18:11]);
      #0.5;
      chk(host_rdata == VEC[i][10:3], "R2 readback", host_rdata, VEC[i][10:3]);
      chk({drive_a, drive_b, ref_sel_b} == VEC[i][2:0], "R3 R4 drives",
          {drive_a, drive_b, ref_sel_b}, VEC[i][2:0]);
    end

    // R11 strobe period
    wait_strobe(t0); wait_strobe(t1);
    chk(t1 - t0 == FLEN, "R11 strobe period", t1 - t0, FLEN);

    // R5 advance in secondary
    wr(2'd0, 8'h11);
    wait_strobe(t0);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h15);
    chk(adv_active == 1'b1, "R5 advance active", adv_active, 1);
    wait_strobe(t1); wait_strobe(t2);
    chk(t1 - t0 == FLEN - 1, "R5 early strobe", t1 - t0, FLEN - 1);
    chk(t2 - t1 == FLEN, "R5 advanced period", t2 - t1, FLEN);
    wr(2'd0, 8'h05);
    chk(adv_active == 1'b0, "R10 advance ignored when primary", adv_active, 0);

    // R10 manual secondary ignores error
    wr(2'd0, 8'h11);
    frm_b_on = 0;
    repeat (120) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h31, "R10 manual keeps secondary", d, 8'h31);
    frm_b_on = 1;
    repeat (60) @(negedge clk);

    // R10 primary ignores error in auto mode
    wr(2'd0, 8'h09);
    frm_b_on = 0;
    repeat (120) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h09, "R10 primary ignores error", d, 8'h09);
    frm_b_on = 1;
    repeat (60) @(negedge clk);

    // R6 healthy reference, R7 R8 promotion by missing frames
    wr(2'd0, 8'h19);
    repeat (120) @(negedge clk);
    chk(role_sec == 1'b1, "R6 no error while healthy", role_sec, 1);
    frm_b_on = 0;
    found = 0; prev_s = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (!role_sec) found = 1;
      else prev_s = frame_strobe;
    end
    chk(found, "R7 promoted after frame loss", found, 1);
    chk(prev_s, "R8 promotion after boundary", prev_s, 1);
    rd(2'd0, d); chk(d == 8'h19, "R7 status primary", d, 8'h19);
    wait_strobe(t0); wait_strobe(t1);
    chk(t1 - t0 == FLEN, "R8 period kept", t1 - t0, FLEN);

    // R9 latched primary
    frm_b_on = 1;
    repeat (60) @(negedge clk);
    wr(2'd0, 8'h19);
    rd(2'd0, d); chk(d == 8'h19, "R9 stays primary in auto", d, 8'h19);
    wr(2'd0, 8'h11);
    rd(2'd0, d); chk(d == 8'h11, "R9 manual returns primary", d, 8'h11);
    wr(2'd0, 8'h11);
    rd(2'd0, d); chk(d == 8'h31, "R9 later write secondary", d, 8'h31);

    // R6 clock stall with R12 write on boundary keeping auto
    wr(2'd0, 8'h19);
    boundary_write(8'h19);
    chk(role_sec == 1'b0, "R12 R6 promote despite write", role_sec, 0);
    clk_b_on = 1;
    repeat (60) @(negedge clk);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h19);
    chk(role_sec == 1'b1, "R9 secondary again", role_sec, 1);

    // R12 write clearing auto on boundary cancels
    boundary_write(8'h11);
    chk(role_sec == 1'b1, "R12 cancel by manual write", role_sec, 1);
    repeat (100) @(negedge clk);
    rd(2'd0, d); chk(d == 8'h31, "R12 stays secondary", d, 8'h31);
    clk_b_on = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule